// File: doc/BRIEF.md
# Privilege-Gated Region Configuration Registers

This block is a small register file that stores the range and policy words of three memory protection regions. Software reads and writes the words over a simple single-cycle register bus. Every write carries one bit naming its privilege level. The stored words are driven out in parallel to a separate access checker.

The block decides whether each write may land. Regions 0 and 1 belong to privileged software. Region 2 may be programmed by non-privileged software, but not with a span that reaches into either privileged region. Both checks are made in hardware in the cycle of the write. A refused write leaves every register untouched, raises a one-cycle error response and sets a sticky violation flag. Only privileged software can clear that flag.

Top module: `region_cfg_regs`

## Requirements
- R1: Word offsets map as follows: 0x00 region 0 range, 0x04 region 0 policy, 0x08 region 1 range, 0x0C region 1 policy, 0x10 region 2 range, 0x14 region 2 policy. A range word holds the base in bits [15:0] and the size in bits [31:16]. A privileged write to any mapped offset stores the data by the next cycle.
- R2: A non-privileged write to any register of region 0 or region 1 is rejected, and the register keeps its value.
- R3: A non-privileged write to the region 2 policy is always accepted. A non-privileged write to the region 2 range is accepted when it overlaps neither privileged region.
- R4: Two ranges overlap when both sizes are non-zero and each base is below the other range's end. The end is base + size, computed in 17 bits so that it cannot wrap. Ranges that only touch (one end equals the other base) do not overlap. A non-privileged region 2 range write that overlaps region 0 or region 1 is rejected.
- R5: A rejected write drives err_o high in the cycle after the write, for exactly one cycle per rejected write, and changes no register.
- R6: viol_o is set by any rejected write. It stays set through non-privileged writes, whether accepted or ignored. It is cleared by a privileged write to a mapped offset.
- R7: Privileged writes are never checked for overlap. This applies to region 2 as well as to regions 0 and 1.
- R8: Reads are allowed at both privilege levels. rdata_o carries the addressed word in the cycle after rd_en_i and holds its value otherwise. An unmapped or misaligned read returns zero.
- R9: Reset clears every region word, err_o, viol_o and rdata_o to zero.
- R10: rng_o and pol_o always show the stored words, with region i in bits [32i+31:32i].
- R11: A write to an offset of 0x18 or above, or to an offset that is not word aligned, is ignored: no register changes and no error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| priv_i | input | 1 | Writer privilege, 1 = privileged |
| addr_i | input | 5 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| err_o | output | 1 | One-cycle error response for a rejected write |
| viol_o | output | 1 | Sticky violation flag |
| rng_o | output | 96 | Range words of all regions |
| pol_o | output | 96 | Policy words of all regions |

## Verification
Suppose a privileged range register were wrongly stored or compared. The fault would show on the next non-privileged region 2 write whose span borders that region: err_o would appear or be missing one cycle after the write, and the region 2 word on rng_o would differ from the expected value. Overlap stimulus covers touching edges, enclosing spans, zero sizes and a privileged range whose end lies above 0xFFFF, so an off-by-one or a truncated end shows up within one write. A flag stuck high or low shows on viol_o right after the first rejected write or the first privileged write.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int unsigned RCFG_NUM_REGIONS = 3;
  localparam int unsigned RCFG_NUM_PRIV    = 2;
  localparam int unsigned RCFG_DATA_W      = 32;
  localparam int unsigned RCFG_ADDR_W      = 5;
endpackage

// File: rtl/rcfg_overlap.sv
module rcfg_overlap #(
  parameter int unsigned HALF_W = 16
) (
  input  logic [HALF_W-1:0] a_base_i,
  input  logic [HALF_W-1:0] a_size_i,
  input  logic [HALF_W-1:0] b_base_i,
  input  logic [HALF_W-1:0] b_size_i,
  output logic              hit_o
);
  logic [HALF_W:0] a_end, b_end;

  // one extra bit keeps the end from wrapping
  assign a_end = {1'b0, a_base_i} + {1'b0, a_size_i};
  assign b_end = {1'b0, b_base_i} + {1'b0, b_size_i};

  assign hit_o = (|a_size_i) && (|b_size_i) &&
                 ({1'b0, a_base_i} < b_end) && ({1'b0, b_base_i} < a_end);
endmodule

// File: rtl/rcfg_rdport.sv
module rcfg_rdport #(
  parameter int unsigned NUM_REGIONS = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_REGIONS*DATA_W-1:0] rng_i,
  input  logic [NUM_REGIONS*DATA_W-1:0] pol_i,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel, rdata_q;

  assign idx = addr_i[ADDR_W-1:3];

  always_comb begin
    sel = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (addr_i[1:0] == 2'b00 && idx == IDX_W'(r))
        sel = addr_i[2] ? pol_i[r*DATA_W +: DATA_W] : rng_i[r*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/region_cfg_regs.sv
module region_cfg_regs #(
  parameter int unsigned NUM_REGIONS = rcfg_pkg::RCFG_NUM_REGIONS,
  parameter int unsigned NUM_PRIV    = rcfg_pkg::RCFG_NUM_PRIV,
  parameter int unsigned DATA_W      = rcfg_pkg::RCFG_DATA_W,
  parameter int unsigned ADDR_W      = rcfg_pkg::RCFG_ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic                          priv_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          err_o,
  output logic                          viol_o,
  output logic [NUM_REGIONS*DATA_W-1:0] rng_o,
  output logic [NUM_REGIONS*DATA_W-1:0] pol_o
);
  localparam int unsigned IDX_W  = ADDR_W - 3;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [IDX_W-1:0]    wr_idx;
  logic                wr_pol, mapped, priv_region, ovl_any, reject, accept;
  logic [NUM_PRIV-1:0] ovl_hit;
  logic                err_q, viol_q;

  assign wr_idx      = addr_i[ADDR_W-1:3];
  assign wr_pol      = addr_i[2];
  assign mapped      = (addr_i[1:0] == 2'b00) && (wr_idx < IDX_W'(NUM_REGIONS));
  assign priv_region = wr_idx < IDX_W'(NUM_PRIV);

  // candidate range against every privileged region
  for (genvar p = 0; p < NUM_PRIV; p++) begin : g_ovl
    rcfg_overlap #(.HALF_W(HALF_W)) u_ovl (
      .a_base_i (wdata_i[HALF_W-1:0]),
      .a_size_i (wdata_i[DATA_W-1:HALF_W]),
      .b_base_i (rng_o[p*DATA_W +: HALF_W]),
      .b_size_i (rng_o[p*DATA_W+HALF_W +: HALF_W]),
      .hit_o    (ovl_hit[p])
    );
  end
  assign ovl_any = |ovl_hit;

  assign reject = wr_en_i && mapped && !priv_i &&
                  (priv_region || (!wr_pol && ovl_any));
  assign accept = wr_en_i && mapped && !reject;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    logic [DATA_W-1:0] rng_q, pol_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rng_q <= '0;
        pol_q <= '0;
      end else if (accept && wr_idx == IDX_W'(r)) begin
        if (wr_pol) pol_q <= wdata_i;
        else        rng_q <= wdata_i;
      end
    end
    assign rng_o[r*DATA_W +: DATA_W] = rng_q;
    assign pol_o[r*DATA_W +: DATA_W] = pol_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      err_q <= reject;
      if (reject)                              viol_q <= 1'b1;
      else if (wr_en_i && mapped && priv_i)    viol_q <= 1'b0;
    end
  end

  assign err_o  = err_q;
  assign viol_o = viol_q;

  rcfg_rdport #(
    .NUM_REGIONS (NUM_REGIONS),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W)
  ) u_rdport (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .rng_i   (rng_o),
    .pol_i   (pol_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/rcfg_chk.sv
module rcfg_chk #(
  parameter int unsigned NUM_REGIONS = 3,
  parameter int unsigned NUM_PRIV    = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic                          rd_en_i,
  input logic                          priv_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             wdata_i,
  input logic [DATA_W-1:0]             rdata_o,
  input logic                          err_o,
  input logic                          viol_o,
  input logic [NUM_REGIONS*DATA_W-1:0] rng_o,
  input logic [NUM_REGIONS*DATA_W-1:0] pol_o
);
  localparam int unsigned PW = NUM_PRIV * DATA_W;

  AST_PRIV_RANGE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && priv_i && addr_i == '0 |=> rng_o[DATA_W-1:0] == $past(wdata_i) && !err_o); // R1

  AST_NP_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !priv_i && addr_i < ADDR_W'(PW/4) |=> $stable(rng_o[PW-1:0]) && $stable(pol_o[PW-1:0])); // R2

  AST_NP_POL_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !priv_i && addr_i == ADDR_W'(PW/4 + 4) |=>
      pol_o[PW +: DATA_W] == $past(wdata_i) && !err_o); // R3

  AST_ERR_MARKS_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> viol_o); // R5

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o && !(wr_en_i && priv_i) |=> viol_o); // R6

  AST_PRIV_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && priv_i |=> !err_o); // R7

  AST_RD_POLICY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && addr_i == ADDR_W'(4) |=> rdata_o == $past(pol_o[DATA_W-1:0])); // R8

  AST_MISALIGNED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i[1:0] != 2'b00 |=> !err_o && $stable(rng_o) && $stable(pol_o)); // R11
endmodule

bind region_cfg_regs rcfg_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .NUM_PRIV    (NUM_PRIV),
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .priv_i  (priv_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .viol_o  (viol_o),
  .rng_o   (rng_o),
  .pol_o   (pol_o)
);

// File: tb/region_cfg_regs_tb.sv
module region_cfg_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 29;

  typedef struct packed {
    logic        rd;
    logic        priv;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;   // err bit for writes, word for reads
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 5'h00, 32'h0100_1000, 32'd0,         4'd1},  // R1 R0 = 0x1000..0x10FF
    '{1'b0, 1'b1, 5'h08, 32'h0080_4000, 32'd0,         4'd1},  // R1 R1 = 0x4000..0x407F
    '{1'b1, 1'b0, 5'h00, 32'h0,         32'h0100_1000, 4'd8},  // R8
    '{1'b0, 1'b0, 5'h04, 32'h0000_000F, 32'd1,         4'd2},  // R2
    '{1'b1, 1'b1, 5'h04, 32'h0,         32'h0,         4'd2},  // R2
    '{1'b0, 1'b0, 5'h08, 32'h0,         32'd1,         4'd2},  // R2
    '{1'b1, 1'b0, 5'h08, 32'h0,         32'h0080_4000, 4'd2},  // R2
    '{1'b0, 1'b0, 5'h10, 32'h0010_10F8, 32'd1,         4'd4},  // R4 tail of R0
    '{1'b1, 1'b0, 5'h10, 32'h0,         32'h0,         4'd5},  // R5 unchanged
    '{1'b0, 1'b0, 5'h10, 32'h0010_1100, 32'd0,         4'd4},  // R4 touching R0 end
    '{1'b1, 1'b0, 5'h10, 32'h0,         32'h0010_1100, 4'd3},  // R3
    '{1'b0, 1'b0, 5'h10, 32'h0010_3FF0, 32'd0,         4'd4},  // R4 touching R1 base
    '{1'b0, 1'b0, 5'h10, 32'h0100_0F80, 32'd1,         4'd4},  // R4 head of R0
    '{1'b0, 1'b0, 5'h10, 32'h1000_0000, 32'd0,         4'd4},  // R4 ends at R0 base
    '{1'b0, 1'b0, 5'h10, 32'h2000_3000, 32'd1,         4'd4},  // R4 encloses R1
    '{1'b0, 1'b0, 5'h10, 32'h0000_1050, 32'd0,         4'd4},  // R4 zero size
    '{1'b1, 1'b1, 5'h10, 32'h0,         32'h0000_1050, 4'd4},  // R4
    '{1'b0, 1'b0, 5'h14, 32'h0000_0007, 32'd0,         4'd3},  // R3
    '{1'b1, 1'b0, 5'h14, 32'h0,         32'h0000_0007, 4'd3},  // R3
    '{1'b0, 1'b1, 5'h10, 32'h0010_1010, 32'd0,         4'd7},  // R7 priv overlap ok
    '{1'b1, 1'b0, 5'h10, 32'h0,         32'h0010_1010, 4'd7},  // R7
    '{1'b0, 1'b0, 5'h18, 32'h0000_0005, 32'd0,         4'd11}, // R11 unmapped
    '{1'b1, 1'b1, 5'h18, 32'h0,         32'h0,         4'd8},  // R8 unmapped read
    '{1'b0, 1'b0, 5'h02, 32'h0000_FFFF, 32'd0,         4'd11}, // R11 misaligned
    '{1'b1, 1'b0, 5'h00, 32'h0,         32'h0100_1000, 4'd11}, // R11
    '{1'b0, 1'b1, 5'h00, 32'h0020_FFF0, 32'd0,         4'd1},  // R1 end above 0xFFFF
    '{1'b0, 1'b0, 5'h10, 32'h0001_FFFF, 32'd1,         4'd4},  // R4 17-bit end
    '{1'b0, 1'b0, 5'h10, 32'h0010_0000, 32'd0,         4'd4},  // R4 no wrap
    '{1'b1, 1'b0, 5'h10, 32'h0,         32'h0010_0000, 4'd4}   // R4
  };

  logic        clk, rst_n, wr_en, rd_en, priv;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        err, viol;
  logic [95:0] rng, pol;
  int          total, bad;

  region_cfg_regs dut_i (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .rd_en_i (rd_en),
    .priv_i (priv), .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
    .err_o (err), .viol_o (viol), .rng_o (rng), .pol_o (pol)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic op(input logic r, input logic p, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    rd_en = r; wr_en = ~r; priv = p; addr = a; wdata = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; priv = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(rng == '0 && pol == '0 && !err && !viol && rdata == '0, "R9", {rng[31:0], pol[31:0], 30'd0, err, viol}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].rd, VEC[i].priv, VEC[i].addr, VEC[i].data);
      if (VEC[i].rd)
        check(rdata == VEC[i].exp, $sformatf("R%0d vec %0d rdata", VEC[i].req, i), rdata, VEC[i].exp);
      else
        check(err == VEC[i].exp[0], $sformatf("R%0d vec %0d err", VEC[i].req, i), err, VEC[i].exp[0]);
    end

    // R5 error lasts one cycle
    idle();
    check(!err, "R5 err pulse", err, 0);
    // R6 flag set by last reject, survives accepted non-priv write
    check(viol, "R6 sticky", viol, 1);
    op(1'b0, 1'b0, 5'h14, 32'h0000_0003);
    check(viol && !err, "R6 np write keeps", {err, viol}, 2'b01);
    // R10 parallel outputs
    check(rng[31:0] == 32'h0020_FFF0 && rng[95:64] == 32'h0010_0000 && pol[95:64] == 32'h3,
          "R10 outputs", {rng[31:0], rng[95:64], pol[95:64]}, {32'h0020_FFF0, 32'h0010_0000, 32'h3});
    // R6 cleared by privileged write
    op(1'b0, 1'b1, 5'h0C, 32'h0000_0011);
    check(!viol, "R6 priv clears", viol, 0);
    check(pol[63:32] == 32'h11, "R1 R1 policy", pol[63:32], 32'h11);
    // R5 back-to-back rejects
    op(1'b0, 1'b0, 5'h00, 32'hDEAD_BEEF);
    check(err && viol, "R5 reject 1", {err, viol}, 2'b11);
    op(1'b0, 1'b0, 5'h0C, 32'hDEAD_BEEF);
    check(err && rng[31:0] == 32'h0020_FFF0 && pol[63:32] == 32'h11, "R2 reject 2", {err, rng[31:0], pol[63:32]}, {1'b1, 32'h0020_FFF0, 32'h11});
    // R9 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(rng == '0 && pol == '0 && !viol && !err && rdata == '0, "R9 reset", {rng[31:0], pol[63:32], 30'd0, err, viol}, '0);
    rst_n = 1'b1;
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule